// File: doc/BRIEF.md
# Register access violation monitor

This block sits beside a peripheral's register file and watches every access on its simple register bus. Each access is a single-cycle strobe carrying direction, byte offset and write data. The block is always ready: there is no ready pin and no back-pressure, so every strobe is classified in the cycle it appears. The block keeps one 32-bit read-only status word, reset to zero. The word records four things: write attempts on protected registers, software misuse of the register map, and two hardware fault flags fed by a clock-glitch detector and an internal sequencer.

Parameters give each word offset a kind: read/write, read-only, write-only, write-protected or undefined. They also name the status, data-output, key-transfer-control and protection-mode offsets. Side inputs give the peripheral enable, a key-transfer-busy level, the current protection bits and the lock bits. Protected registers are guarded by protection bit 0. A read of the status offset returns the current word on `status_word` during that cycle and clears it from the next cycle on. The block also issues the key-transfer start pulse, and it refuses that pulse while a transfer is running.

Top module: `acc_viol_mon`

## Requirements
- R1: After reset every field of `status_word` is zero. Field positions are: bit0 protection violation flag, bit1 glitch flag, bit2 sequencer flag, bit3 software error flag, bits 23:8 captured 16-bit offset, bits 27:24 error type, bit31 class (1 = error, 0 = warning). All other bits are always zero.
- R2: A read of the status offset (default 0x10) clears every field, starting the cycle after the read. A status read never raises a software error.
- R3: While `periph_en` is high, a read of a write-only offset raises type 0 and a write to a read-only offset raises type 1. Both are warnings. While `periph_en` is low, neither is flagged.
- R4: An access to an undefined offset raises type 2, a warning, whatever the enable. Undefined offsets are offsets marked undefined, offsets past the map, and offsets that are not word-aligned.
- R5: A read of the data-output offset (default 0x0C) while disabled or while `xfer_busy` is high raises type 3, class error.
- R6: A write to the key-transfer-control offset (default 0x04) while `xfer_busy` is high raises type 4, class error, and gives no `xfer_start`. When not busy, the write pulses `xfer_start` for one cycle, one cycle later.
- R7: A write to the protection-mode offset (default 0x08) raises type 5, a warning, when write data bits [1:0] would clear a protection bit that is set and whose lock bit is set.
- R8: A write to a write-protected offset while `prot_bits[0]` is high sets bit0 and captures the offset in bits 23:8. A later such violation replaces the captured offset. A software error captures its offset only while bit0 is clear.
- R9: A one-cycle pulse on `glitch_pulse` or `seq_fault_pulse` sets bit1 or bit2 respectively, and the bit stays set until the next status read.
- R10: When several software errors occur between status reads, bit3 stays set and the type and class of the first error are kept.
- R11: A glitch or sequencer pulse in the same cycle as a status read is not lost. Its flag is set in the word after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Single-cycle access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | AW (16) | Byte offset of the access |
| acc_wdata | input | DW (32) | Write data |
| periph_en | input | 1 | Peripheral enable level |
| xfer_busy | input | 1 | Key transfer in progress |
| prot_bits | input | NPROT (2) | Current protection bits; bit 0 guards protected registers |
| lock_bits | input | NPROT (2) | Lock bits for the protection bits |
| glitch_pulse | input | 1 | Clock-glitch detector event |
| seq_fault_pulse | input | 1 | Internal sequencer fault event |
| status_word | output | 32 | Status word; clears after a status read |
| xfer_start | output | 1 | Key-transfer start pulse |

## Verification
Every result passes through exactly one register. A strobe or pulse presented before a rising edge therefore shows on `status_word` and `xfer_start` right after that edge, and a status read shows zero, plus any event from the same cycle, one edge later. The bench drives inputs just after each rising edge and updates its reference model at the same edge from the inputs then present. It compares both outputs against the model at the following falling edge, so each expected value is checked in exactly the cycle it is due.

// File: rtl/avm_pkg.sv
package avm_pkg;

  typedef enum logic [2:0] {
    K_UNDEF = 3'd0,
    K_RW    = 3'd1,
    K_RO    = 3'd2,
    K_WO    = 3'd3,
    K_WP    = 3'd4
  } kind_e;

  typedef enum logic [3:0] {
    T_RD_WO     = 4'd0,
    T_WR_RO     = 4'd1,
    T_UNDEF     = 4'd2,
    T_DOUT_OFF  = 4'd3,
    T_XFER_BUSY = 4'd4,
    T_LOCK      = 4'd5
  } swtype_e;

  typedef struct packed {
    logic        cls;
    logic [2:0]  rsv_hi;
    logic [3:0]  typ;
    logic [15:0] addr;
    logic [3:0]  rsv_lo;
    logic        swe;
    logic        seqe;
    logic        cgd;
    logic        wpvs;
  } stat_t;

  typedef struct packed {
    logic        sw;
    swtype_e     typ;
    logic        wpv;
    logic [15:0] addr;
  } ev_t;

  function automatic logic is_error_class(input logic [3:0] t);
    return (t == 4'(T_DOUT_OFF)) || (t == 4'(T_XFER_BUSY));
  endfunction

endpackage

// File: rtl/avm_decode.sv
module avm_decode
  import avm_pkg::*;
#(
  parameter int AW        = 16,
  parameter int NREGS     = 16,
  parameter int NPROT     = 2,
  parameter logic [3*NREGS-1:0] REG_KIND = '0,
  parameter int STAT_OFF  = 16,
  parameter int DOUT_OFF  = 12,
  parameter int XCTL_OFF  = 4,
  parameter int PMODE_OFF = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             write,
  input  logic [AW-1:0]    addr,
  input  logic [NPROT-1:0] wdata,
  input  logic             en,
  input  logic             busy,
  input  logic [NPROT-1:0] prot,
  input  logic [NPROT-1:0] lock,
  output ev_t              ev,
  output logic             stat_rd,
  output logic             xfer_go
);

  localparam int IW = (NREGS > 1) ? $clog2(NREGS) : 1;

  kind_e          kinds [NREGS];
  kind_e          kind;
  logic           in_range;
  logic [IW-1:0]  idx;
  logic           is_stat, is_dout, is_xctl, is_pmode;

  for (genvar g = 0; g < NREGS; g++) begin : g_kind
    assign kinds[g] = kind_e'(REG_KIND[3*g +: 3]);
  end

  assign idx      = addr[IW+1:2];
  assign in_range = (addr[1:0] == 2'b00) && (addr[AW-1:2] < (AW-2)'(NREGS));
  assign kind     = in_range ? kinds[idx] : K_UNDEF;

  assign is_stat  = (addr == AW'(STAT_OFF));
  assign is_dout  = (addr == AW'(DOUT_OFF));
  assign is_xctl  = (addr == AW'(XCTL_OFF));
  assign is_pmode = (addr == AW'(PMODE_OFF));

  always_comb begin
    ev      = '0;
    ev.addr = 16'(addr);
    stat_rd = 1'b0;
    xfer_go = 1'b0;
    if (valid) begin
      if (kind == K_UNDEF) begin
        ev.sw  = 1'b1;
        ev.typ = T_UNDEF;
      end else if (write) begin
        if (kind == K_WP && prot[0]) begin
          ev.wpv = 1'b1;
        end else if (is_xctl && busy) begin
          ev.sw  = 1'b1;
          ev.typ = T_XFER_BUSY;
        end else if (is_xctl) begin
          xfer_go = 1'b1;
        end else if (is_pmode && |(lock & prot & ~wdata)) begin
          ev.sw  = 1'b1;
          ev.typ = T_LOCK;
        end else if (kind == K_RO && en) begin
          ev.sw  = 1'b1;
          ev.typ = T_WR_RO;
        end
      end else begin
        if (is_stat) begin
          stat_rd = 1'b1;
        end else if (is_dout && (!en || busy)) begin
          ev.sw  = 1'b1;
          ev.typ = T_DOUT_OFF;
        end else if (kind == K_WO && en) begin
          ev.sw  = 1'b1;
          ev.typ = T_RD_WO;
        end
      end
    end
  end

  assert_stat_read_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !write && addr == AW'(STAT_OFF)) |-> !ev.sw);

  assert_warn_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.sw && (ev.typ == T_RD_WO || ev.typ == T_WR_RO)) |-> en);

endmodule

// File: rtl/avm_status.sv
module avm_status
  import avm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  ev_t   ev,
  input  logic  rd_clr,
  input  logic  glitch,
  input  logic  seqf,
  output stat_t q
);

  stat_t base, nxt;

  always_comb begin
    base = rd_clr ? '0 : q;
    nxt  = base;
    nxt.rsv_hi = '0;
    nxt.rsv_lo = '0;
    if (glitch) nxt.cgd  = 1'b1;
    if (seqf)   nxt.seqe = 1'b1;
    if (ev.sw) begin
      nxt.swe = 1'b1;
      if (!base.swe) begin
        nxt.typ = ev.typ;
        nxt.cls = is_error_class(ev.typ);
      end
    end
    if (ev.wpv) begin
      nxt.wpvs = 1'b1;
      nxt.addr = ev.addr;
    end else if (ev.sw && !base.swe && !base.wpvs) begin
      nxt.addr = ev.addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  assert_clear_on_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !ev.sw && !ev.wpv && !glitch && !seqf) |=> (q == '0));

  assert_violation_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev.wpv |=> (q.wpvs && q.addr == $past(ev.addr)));

  assert_glitch_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (q.cgd && !rd_clr) |=> q.cgd);

  assert_glitch_not_lost_R11: assert property (@(posedge clk) disable iff (!rst_n)
    glitch |=> q.cgd);

  assert_first_type_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (q.swe && !rd_clr) |=> (q.typ == $past(q.typ) && q.cls == $past(q.cls)));

endmodule

// File: rtl/acc_viol_mon.sv
module acc_viol_mon
  import avm_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int NREGS     = 16,
  parameter int NPROT     = 2,
  parameter logic [3*NREGS-1:0] REG_KIND = 48'd1156188,
  parameter int STAT_OFF  = 16,
  parameter int DOUT_OFF  = 12,
  parameter int XCTL_OFF  = 4,
  parameter int PMODE_OFF = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [AW-1:0]    acc_addr,
  input  logic [DW-1:0]    acc_wdata,
  input  logic             periph_en,
  input  logic             xfer_busy,
  input  logic [NPROT-1:0] prot_bits,
  input  logic [NPROT-1:0] lock_bits,
  input  logic             glitch_pulse,
  input  logic             seq_fault_pulse,
  output logic [31:0]      status_word,
  output logic             xfer_start
);

  ev_t   ev;
  logic  stat_rd;
  logic  xfer_go;
  stat_t stat_q;
  logic  xfer_q;
  logic  unused_wdata;

  assign unused_wdata = ^acc_wdata[DW-1:NPROT];

  avm_decode #(
    .AW(AW), .NREGS(NREGS), .NPROT(NPROT), .REG_KIND(REG_KIND),
    .STAT_OFF(STAT_OFF), .DOUT_OFF(DOUT_OFF),
    .XCTL_OFF(XCTL_OFF), .PMODE_OFF(PMODE_OFF)
  ) u_decode (
    .clk(clk), .rst_n(rst_n),
    .valid(acc_valid), .write(acc_write), .addr(acc_addr),
    .wdata(acc_wdata[NPROT-1:0]), .en(periph_en), .busy(xfer_busy),
    .prot(prot_bits), .lock(lock_bits),
    .ev(ev), .stat_rd(stat_rd), .xfer_go(xfer_go)
  );

  avm_status u_status (
    .clk(clk), .rst_n(rst_n), .ev(ev), .rd_clr(stat_rd),
    .glitch(glitch_pulse), .seqf(seq_fault_pulse), .q(stat_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xfer_q <= 1'b0;
    else        xfer_q <= xfer_go;
  end

  assign status_word = stat_q;
  assign xfer_start  = xfer_q;

  assert_no_start_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_addr == AW'(XCTL_OFF) && xfer_busy) |=> !xfer_start);

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[30:28] == 3'b000 && status_word[7:4] == 4'b0000));

endmodule

// File: tb/acc_viol_mon_tb.sv
module acc_viol_mon_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [15:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic        periph_en = 1'b0, xfer_busy = 1'b0;
  logic [1:0]  prot_bits = '0, lock_bits = '0;
  logic        glitch_pulse = 1'b0, seq_fault_pulse = 1'b0;
  logic [31:0] status_word;
  logic        xfer_start;

  int compared = 0, mismatched = 0, cyc = 0;
  bit started = 0;
  string cur_req = "R1";

  // reference model state
  bit m_wpvs, m_cgd, m_seqe, m_swe, m_cls, m_go;
  int m_addr, m_typ;

  always #4 clk = ~clk;

  acc_viol_mon dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .periph_en(periph_en),
    .xfer_busy(xfer_busy), .prot_bits(prot_bits), .lock_bits(lock_bits),
    .glitch_pulse(glitch_pulse), .seq_fault_pulse(seq_fault_pulse),
    .status_word(status_word), .xfer_start(xfer_start)
  );

  // Map: 0x00 protected, 0x04 xfer ctl (WO), 0x08 prot mode, 0x0C data out (RO),
  // 0x10 status (RO), 0x14 key (WO), 0x18 protected; all else undefined.
  function automatic void classify(output int t, output bit wpv, output bit go);
    bit defd;
    t = -1; wpv = 0; go = 0;
    if (!acc_valid) return;
    defd = (acc_addr[1:0] == 0) && (acc_addr <= 16'h18);
    if (!defd) t = 2;
    else if (acc_write) begin
      if ((acc_addr == 16'h00 || acc_addr == 16'h18) && prot_bits[0]) wpv = 1;
      else if (acc_addr == 16'h04) begin if (xfer_busy) t = 4; else go = 1; end
      else if (acc_addr == 16'h08 && (lock_bits & prot_bits & ~acc_wdata[1:0]) != 0) t = 5;
      else if ((acc_addr == 16'h0C || acc_addr == 16'h10) && periph_en) t = 1;
    end else begin
      if (acc_addr == 16'h10) t = -1;
      else if (acc_addr == 16'h0C && (!periph_en || xfer_busy)) t = 3;
      else if ((acc_addr == 16'h04 || acc_addr == 16'h14) && periph_en) t = 0;
    end
  endfunction

  always @(posedge clk) begin
    int t; bit wpv, go;
    started <= 1;
    if (!rst_n) begin
      {m_wpvs, m_cgd, m_seqe, m_swe, m_cls, m_go} = '0;
      m_addr = 0; m_typ = 0;
    end else begin
      classify(t, wpv, go);
      if (acc_valid && !acc_write && acc_addr == 16'h10) begin
        {m_wpvs, m_cgd, m_seqe, m_swe, m_cls} = '0;
        m_addr = 0; m_typ = 0;
      end
      if (glitch_pulse) m_cgd = 1;
      if (seq_fault_pulse) m_seqe = 1;
      if (t >= 0) begin
        if (!m_swe) begin
          m_typ = t; m_cls = (t == 3 || t == 4);
          if (!m_wpvs) m_addr = acc_addr;
        end
        m_swe = 1;
      end
      if (wpv) begin m_wpvs = 1; m_addr = acc_addr; end
      m_go = go;
    end
  end

  always @(negedge clk) begin
    logic [31:0] exp_w;
    if (started) begin
      exp_w = {m_cls, 3'b000, 4'(m_typ), 16'(m_addr), 4'b0000, m_swe, m_seqe, m_cgd, m_wpvs};
      compared++;
      if (status_word !== exp_w || xfer_start !== m_go) begin
        mismatched++;
        $display("FAIL %s cycle %0d: status=%h start=%b expected status=%h start=%b",
                 cur_req, cyc, status_word, xfer_start, exp_w, m_go);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      mismatched++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic acc(input bit w, input logic [15:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    acc_valid = 1; acc_write = w; acc_addr = a; acc_wdata = d;
    @(posedge clk); #1;
    acc_valid = 0; acc_write = 0;
  endtask

  task automatic rd_stat();
    acc(0, 16'h10, 0);
    idle(1);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    cur_req = "R1"; idle(3);

    cur_req = "R3"; periph_en = 0;
    acc(0, 16'h14, 0); acc(1, 16'h0C, 0); idle(2);
    cur_req = "R5"; acc(0, 16'h0C, 0); idle(2);
    cur_req = "R2"; rd_stat(); idle(1);

    cur_req = "R3"; periph_en = 1;
    acc(0, 16'h14, 0); idle(1); rd_stat();
    acc(1, 16'h10, 0); idle(1); rd_stat();
    acc(0, 16'h04, 0); idle(1); rd_stat();

    cur_req = "R4"; periph_en = 0;
    acc(0, 16'h40, 0); idle(1); rd_stat();
    acc(1, 16'h05, 0); idle(1); rd_stat();
    acc(0, 16'h1C, 0); idle(1); rd_stat();

    cur_req = "R5"; periph_en = 1; xfer_busy = 1;
    acc(0, 16'h0C, 0); idle(1); rd_stat();
    cur_req = "R6";
    acc(1, 16'h04, 1); idle(2); rd_stat();
    xfer_busy = 0;
    acc(1, 16'h04, 1); idle(2);

    cur_req = "R7"; prot_bits = 2'b11; lock_bits = 2'b01;
    acc(1, 16'h08, 32'h0); idle(1); rd_stat();
    acc(1, 16'h08, 32'h1); idle(1);
    lock_bits = 2'b10; acc(1, 16'h08, 32'h1); idle(1); rd_stat();

    cur_req = "R8"; lock_bits = 0; prot_bits = 2'b01;
    acc(1, 16'h00, 0); idle(1);
    acc(0, 16'h44, 0); idle(1); rd_stat();
    acc(0, 16'h48, 0); idle(1);
    acc(1, 16'h18, 0); idle(1);
    acc(1, 16'h00, 0); idle(1); rd_stat();
    prot_bits = 0; acc(1, 16'h18, 0); idle(1);

    cur_req = "R10"; periph_en = 0;
    acc(0, 16'h0C, 0); acc(0, 16'h50, 0); acc(1, 16'h10, 0); idle(1); rd_stat();

    cur_req = "R9";
    @(posedge clk); #1 glitch_pulse = 1; @(posedge clk); #1 glitch_pulse = 0;
    idle(3);
    @(posedge clk); #1 seq_fault_pulse = 1; @(posedge clk); #1 seq_fault_pulse = 0;
    idle(3); rd_stat();

    cur_req = "R11";
    @(posedge clk); #1;
    acc_valid = 1; acc_addr = 16'h10; acc_write = 0; glitch_pulse = 1; seq_fault_pulse = 1;
    @(posedge clk); #1;
    acc_valid = 0; glitch_pulse = 0; seq_fault_pulse = 0;
    idle(2); rd_stat(); idle(2);

    cur_req = "R1"; rst_n = 0; idle(2); rst_n = 1; idle(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule